// File: doc/BRIEF.md
# Privilege- and Thread-Tagged Indirect Target Predictor

This block predicts where an indirect jump or call will go, that is, a branch whose destination is read from a register. It is a direct-mapped table. A few low bits of the fetch address pick one slot, and a short partial tag taken from the bits just above them confirms the match. Because only part of the address is compared, two branches at different addresses can share an entry, and each can steer the other.

Every entry records the privilege level and the hardware thread that trained it. A two-bit mode register can turn on two filters:
- Restricted mode stops a kernel-mode lookup from using an entry that user code trained.
- Thread isolation stops one hardware thread from using an entry that its sibling trained.

Both filters act when a lookup is made, so changing the mode never rewrites the table. A barrier command starts a sweep that clears the whole table, one entry per cycle. While the sweep runs, lookups miss and training writes are thrown away.

The fetch side presents an address, a privilege flag and a thread number, and gets back hit and target in the same cycle. The resolve side presents an address, the real target, the privilege level and the thread, and the write takes effect at the next clock edge.

Top module: `xbtb_top`

## Requirements
- R1: With both mode bits clear, a lookup hits and returns the stored target when the entry selected by lk_pc[6:2] is valid and its tag equals lk_pc[14:7]. With a different tag on the same entry, the lookup misses. On any miss, lk_target reads zero.
- R2: Address bits below bit 2 and above bit 14 take no part in the lookup. A lookup whose address differs from a trained address only in those bits hits that entry and returns its target.
- R3: When spec_ctrl bit 0 (restricted mode) is 1, a kernel lookup (lk_kernel=1) of an entry trained with up_kernel=0 misses. A user lookup of the same entry still hits, and a kernel lookup of a kernel-trained entry hits.
- R4: The mode bits change only on a cfg_we write and keep their value across any sequence of lookups and training at either privilege level. Clearing bit 0 lets a kernel lookup use a user-trained entry again without any retraining.
- R5: When spec_ctrl bit 1 (thread isolation) is 1, a lookup misses unless lk_tid equals the thread that trained the entry. When bit 1 is 0, the sibling thread hits.
- R6: A bar_req pulse while no sweep is running raises bar_busy at the next edge. bar_busy then stays high for exactly 32 cycles, one per entry. Every lookup misses while bar_busy is high, and no entry trained before the barrier hits after the sweep ends.
- R7: A training request made while bar_busy is high, or in the same cycle as an accepted bar_req, is discarded.
- R8: Training overwrites the whole entry: its target, tag, privilege flag and thread number are all replaced at once.
- R9: After reset, every entry is invalid, spec_ctrl is 0 and bar_busy is 0.
- R10: A bar_req pulse while a sweep is already running is ignored, and the sweep keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_wdata | input | 2 | New mode: bit 0 restricted, bit 1 thread isolation |
| spec_ctrl | output | 2 | Current mode register |
| bar_req | input | 1 | Barrier request pulse |
| bar_busy | output | 1 | Clearing sweep in progress |
| lk_pc | input | 32 | Fetch address to look up |
| lk_kernel | input | 1 | Lookup made in kernel mode |
| lk_tid | input | 1 | Thread making the lookup |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | 32 | Predicted target (zero on miss) |
| up_valid | input | 1 | Training request |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Actual target |
| up_kernel | input | 1 | Trainer ran in kernel mode |
| up_tid | input | 1 | Trainer thread |

## Verification
The hardest cases to reach are training and barrier requests that arrive while a sweep is already running. From the ports, they can only be placed at exact cycles within the 32-cycle window. The bench drives the barrier and then counts the busy cycles at falling edges. At fixed counts inside that window it injects a training write to entry 0, which the sweep has already passed, and a second barrier pulse. A design that accepts the late write leaves entry 0 hitting after the sweep. A design that restarts on the second pulse stretches the busy window past 32 cycles.

// File: rtl/xbtb_pkg.sv
package xbtb_pkg;
    localparam int MODE_W      = 2;
    localparam int MB_RESTRICT = 0;
    localparam int MB_ISOLATE  = 1;

    typedef enum logic {
        SWEEP_IDLE = 1'b0,
        SWEEP_RUN  = 1'b1
    } sweep_e;
endpackage

// File: rtl/xbtb_split.sv
module xbtb_split #(
    parameter int PC_W  = 32,
    parameter int ALIGN = 2,
    parameter int IDX_W = 5,
    parameter int TAG_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int HI = ALIGN + IDX_W + TAG_W;

    assign idx = pc[ALIGN +: IDX_W];
    assign tag = pc[ALIGN + IDX_W +: TAG_W];

    // Alignment bits and bits above the partial tag are deliberately ignored.
    generate
        if (ALIGN > 0) begin : g_lo
            logic lo_unused;
            assign lo_unused = ^pc[ALIGN-1:0];
        end
        if (PC_W > HI) begin : g_hi
            logic hi_unused;
            assign hi_unused = ^pc[PC_W-1:HI];
        end
    endgenerate
endmodule

// File: rtl/xbtb_ctrl.sv
module xbtb_ctrl
    import xbtb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    input  logic              bar_req,
    output logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              clr_en,
    output logic [IDX_W-1:0]  clr_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'((1 << IDX_W) - 1);

    typedef struct packed {
        sweep_e            st;
        logic [IDX_W-1:0]  ptr;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (cfg_we) begin
            c_d.mode = cfg_wdata;
        end
        unique case (c_q.st)
            SWEEP_IDLE: begin
                if (bar_req) begin
                    c_d.st  = SWEEP_RUN;
                    c_d.ptr = '0;
                end
            end
            SWEEP_RUN: begin
                if (c_q.ptr == LAST) begin
                    c_d.st  = SWEEP_IDLE;
                    c_d.ptr = '0;
                end else begin
                    c_d.ptr = c_q.ptr + 1'b1;
                end
            end
            default: c_d.st = SWEEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: SWEEP_IDLE, ptr: '0, mode: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mode    = c_q.mode;
    assign busy    = (c_q.st == SWEEP_RUN);
    assign clr_en  = busy;
    assign clr_idx = c_q.ptr;

    AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bar_req) |=> (busy && clr_idx == '0)); // R6
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_idx == LAST) |=> !busy); // R6
    AST_SWEEP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_idx != LAST) |=> (busy && clr_idx == IDX_W'($past(clr_idx) + 1'b1))); // R10
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(mode)); // R4
endmodule

// File: rtl/xbtb_store.sv
module xbtb_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 8,
    parameter int TGT_W = 32,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             wr_kern,
    input  logic [TID_W-1:0] wr_tid,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt,
    output logic             rd_kern,
    output logic [TID_W-1:0] rd_tid
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic             kern;
        logic [TID_W-1:0] tid;
        logic [TAG_W-1:0] tag;
        logic [TGT_W-1:0] tgt;
    } ent_t;

    ent_t ent_d [DEPTH];
    ent_t ent_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = '{vld: 1'b1, kern: wr_kern, tid: wr_tid,
                              tag: wr_tag, tgt: wr_tgt};
        end
        if (clr_en) begin
            ent_d[clr_idx] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign rd_vld  = ent_q[rd_idx].vld;
    assign rd_tag  = ent_q[rd_idx].tag;
    assign rd_tgt  = ent_q[rd_idx].tgt;
    assign rd_kern = ent_q[rd_idx].kern;
    assign rd_tid  = ent_q[rd_idx].tid;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(clr_en && clr_idx == wr_idx)) |=>
        (ent_q[$past(wr_idx)].vld && ent_q[$past(wr_idx)].tag == $past(wr_tag) &&
         ent_q[$past(wr_idx)].tgt == $past(wr_tgt) &&
         ent_q[$past(wr_idx)].kern == $past(wr_kern) &&
         ent_q[$past(wr_idx)].tid == $past(wr_tid))); // R8
    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !ent_q[$past(clr_idx)].vld); // R6
endmodule

// File: rtl/xbtb_filter.sv
module xbtb_filter
    import xbtb_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int TGT_W = 32,
    parameter int TID_W = 1
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              busy,
    input  logic              lk_kern,
    input  logic [TID_W-1:0]  lk_tid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              rd_vld,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [TGT_W-1:0]  rd_tgt,
    input  logic              rd_kern,
    input  logic [TID_W-1:0]  rd_tid,
    output logic              hit,
    output logic [TGT_W-1:0]  tgt
);
    logic tag_ok, priv_block, thr_block;

    always_comb begin
        tag_ok     = rd_vld && (rd_tag == lk_tag);
        priv_block = mode[MB_RESTRICT] && lk_kern && !rd_kern;
        thr_block  = mode[MB_ISOLATE] && (rd_tid != lk_tid);
        hit        = tag_ok && !priv_block && !thr_block && !busy;
        tgt        = hit ? rd_tgt : '0;
    end
endmodule

// File: rtl/xbtb_top.sv
module xbtb_top
    import xbtb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TGT_W = 32,
    parameter int ALIGN = 2,
    parameter int IDX_W = 5,
    parameter int TAG_W = 8,
    parameter int TID_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MODE_W-1:0] cfg_wdata,
    output logic [MODE_W-1:0] spec_ctrl,
    input  logic              bar_req,
    output logic              bar_busy,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic              lk_kernel,
    input  logic [TID_W-1:0]  lk_tid,
    output logic              lk_hit,
    output logic [TGT_W-1:0]  lk_target,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [TGT_W-1:0]  up_target,
    input  logic              up_kernel,
    input  logic [TID_W-1:0]  up_tid
);
    logic [IDX_W-1:0] lk_idx, up_idx, clr_idx;
    logic [TAG_W-1:0] lk_tag, up_tag, rd_tag;
    logic [TGT_W-1:0] rd_tgt;
    logic [TID_W-1:0] rd_tid;
    logic             rd_vld, rd_kern, clr_en, busy, wr_en;
    logic [MODE_W-1:0] mode;

    xbtb_split #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag));
    xbtb_split #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
        .pc(up_pc), .idx(up_idx), .tag(up_tag));

    xbtb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bar_req(bar_req), .mode(mode), .busy(busy),
        .clr_en(clr_en), .clr_idx(clr_idx));

    // Training is refused during a sweep and in the cycle a barrier is accepted.
    assign wr_en = up_valid && !busy && !bar_req;

    xbtb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W), .TID_W(TID_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(up_target),
        .wr_kern(up_kernel), .wr_tid(up_tid),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .rd_idx(lk_idx), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .rd_kern(rd_kern), .rd_tid(rd_tid));

    xbtb_filter #(.TAG_W(TAG_W), .TGT_W(TGT_W), .TID_W(TID_W)) u_filter (
        .mode(mode), .busy(busy), .lk_kern(lk_kernel), .lk_tid(lk_tid),
        .lk_tag(lk_tag), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .rd_kern(rd_kern), .rd_tid(rd_tid), .hit(lk_hit), .tgt(lk_target));

    assign spec_ctrl = mode;
    assign bar_busy  = busy;

    AST_BUSY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        bar_busy |-> !lk_hit); // R6
    AST_PRIV_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_ctrl[MB_RESTRICT] && lk_kernel && lk_hit) |-> rd_kern); // R3
    AST_THREAD_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_ctrl[MB_ISOLATE] && lk_hit) |-> (rd_tid == lk_tid)); // R5
    AST_HIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (rd_vld && lk_target == rd_tgt)); // R1
    AST_NO_TRAIN_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        bar_busy |-> !wr_en); // R7
endmodule

// File: tb/tb_xbtb_top.sv
module tb_xbtb_top;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_wdata = '0;
    logic [1:0]  spec_ctrl;
    logic        bar_req = 1'b0;
    logic        bar_busy;
    logic [31:0] lk_pc = '0;
    logic        lk_kernel = 1'b0;
    logic [0:0]  lk_tid = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [31:0] up_target = '0;
    logic        up_kernel = 1'b0;
    logic [0:0]  up_tid = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xbtb_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .spec_ctrl(spec_ctrl), .bar_req(bar_req), .bar_busy(bar_busy),
        .lk_pc(lk_pc), .lk_kernel(lk_kernel), .lk_tid(lk_tid),
        .lk_hit(lk_hit), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_target(up_target),
        .up_kernel(up_kernel), .up_tid(up_tid));

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] pc, input logic [31:0] tgt,
                         input logic k, input logic t);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tgt; up_kernel = k; up_tid = t;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc, input logic k, input logic t,
                        input bit exp_hit, input logic [31:0] exp_tgt, input string req);
        lk_pc = pc; lk_kernel = k; lk_tid = t;
        #1;
        chk({lk_hit, lk_target} == {exp_hit, (exp_hit ? exp_tgt : 32'h0)}, req,
            {31'h0, lk_hit, lk_target}, {31'h0, exp_hit, (exp_hit ? exp_tgt : 32'h0)});
    endtask

    task automatic t_reset();
        chk(spec_ctrl == 2'b00, "R9 mode", 64'(spec_ctrl), 64'h0);
        chk(bar_busy == 1'b0, "R9 busy", 64'(bar_busy), 64'h0);
        look(32'h0000_0000, 1'b0, 1'b0, 0, 0, "R9 empty a");
        look(32'h1234_5678, 1'b1, 1'b1, 0, 0, "R9 empty b");
    endtask

    task automatic t_basic();
        train(32'h1000_0044, 32'hAAAA_0001, 1'b0, 1'b0);
        look(32'h1000_0044, 1'b0, 1'b0, 1, 32'hAAAA_0001, "R1 hit");
        look(32'h1000_0044 + 32'h80, 1'b0, 1'b0, 0, 0, "R1 tag miss");
        look(32'h1000_0048, 1'b0, 1'b0, 0, 0, "R1 other index");
    endtask

    task automatic t_alias();
        look(32'h1000_0044 + 32'h8000, 1'b0, 1'b0, 1, 32'hAAAA_0001, "R2 alias high");
        look(32'h5000_0047, 1'b1, 1'b1, 1, 32'hAAAA_0001, "R2 alias low+high");
    endtask

    task automatic t_restrict();
        set_mode(2'b01);
        train(32'h0000_0108, 32'hBBBB_0002, 1'b0, 1'b0);
        train(32'h0000_020C, 32'hCCCC_0003, 1'b1, 1'b0);
        look(32'h0000_0108, 1'b1, 1'b0, 0, 0, "R3 kernel on user entry");
        look(32'h0000_0108, 1'b0, 1'b0, 1, 32'hBBBB_0002, "R3 user on user entry");
        look(32'h0000_020C, 1'b1, 1'b0, 1, 32'hCCCC_0003, "R3 kernel on kernel entry");
        for (int i = 0; i < 3; i++) begin
            train(32'h0000_0310 + 32'(i * 4), 32'h1, 1'(i), 1'b0);
            look(32'h0000_0108, 1'b0, 1'b0, 1, 32'hBBBB_0002, "R4 user after switch");
            look(32'h0000_0108, 1'b1, 1'b0, 0, 0, "R4 kernel after switch");
        end
        chk(spec_ctrl == 2'b01, "R4 mode held", 64'(spec_ctrl), 64'h1);
        set_mode(2'b00);
        look(32'h0000_0108, 1'b1, 1'b0, 1, 32'hBBBB_0002, "R4 mode cleared");
    endtask

    task automatic t_isolate();
        set_mode(2'b10);
        train(32'h0000_0414, 32'hDDDD_0004, 1'b0, 1'b0);
        look(32'h0000_0414, 1'b0, 1'b1, 0, 0, "R5 sibling blocked");
        look(32'h0000_0414, 1'b0, 1'b0, 1, 32'hDDDD_0004, "R5 own thread");
        set_mode(2'b00);
        look(32'h0000_0414, 1'b0, 1'b1, 1, 32'hDDDD_0004, "R5 sibling allowed");
        set_mode(2'b11);
        look(32'h0000_0414, 1'b1, 1'b0, 0, 0, "R5 both modes kernel");
        look(32'h0000_0414, 1'b0, 1'b1, 0, 0, "R5 both modes sibling");
        look(32'h0000_0414, 1'b0, 1'b0, 1, 32'hDDDD_0004, "R5 both modes own");
        set_mode(2'b00);
    endtask

    task automatic t_overwrite();
        train(32'h0000_0518, 32'hEEEE_0005, 1'b0, 1'b0);
        train(32'h0000_0598, 32'hFFFF_0006, 1'b1, 1'b1);
        look(32'h0000_0518, 1'b0, 1'b0, 0, 0, "R8 old tag gone");
        look(32'h0000_0598, 1'b1, 1'b1, 1, 32'hFFFF_0006, "R8 new target");
        set_mode(2'b01);
        look(32'h0000_0598, 1'b1, 1'b0, 1, 32'hFFFF_0006, "R8 privilege replaced");
        set_mode(2'b10);
        look(32'h0000_0598, 1'b0, 1'b0, 0, 0, "R8 thread replaced");
        set_mode(2'b00);
    endtask

    task automatic t_barrier();
        int n;
        train(32'h0000_0000, 32'h0101_0101, 1'b0, 1'b0);
        train(32'h0000_007C, 32'h0202_0202, 1'b1, 1'b1);
        look(32'h0000_0000, 1'b0, 1'b0, 1, 32'h0101_0101, "R6 pre-barrier");
        @(negedge clk);
        bar_req = 1'b1;
        @(negedge clk);
        bar_req = 1'b0;
        chk(bar_busy == 1'b1, "R6 busy raised", 64'(bar_busy), 64'h1);
        look(32'h0000_007C, 1'b1, 1'b1, 0, 0, "R6 miss during sweep");
        n = 0;
        while (bar_busy && n < 1000) begin
            n++;
            if (n == 3) begin
                up_valid = 1'b1; up_pc = 32'h0000_0000; up_target = 32'h0909_0909;
                up_kernel = 1'b0; up_tid = 1'b0;
            end
            if (n == 10) bar_req = 1'b1;
            @(negedge clk);
            up_valid = 1'b0;
            bar_req = 1'b0;
        end
        chk(n == DEPTH, "R6 R10 sweep length", 64'(n), 64'(DEPTH));
        look(32'h0000_007C, 1'b1, 1'b1, 0, 0, "R6 wiped entry");
        look(32'h0000_0108, 1'b0, 1'b0, 0, 0, "R6 wiped older entry");
        look(32'h0000_0000, 1'b0, 1'b0, 0, 0, "R7 late train dropped");
        train(32'h0000_0000, 32'h0303_0303, 1'b0, 1'b0);
        look(32'h0000_0000, 1'b0, 1'b0, 1, 32'h0303_0303, "R6 train after sweep");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_alias();
        t_restrict();
        t_isolate();
        t_overwrite();
        t_barrier();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule